// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block is one 8-bit pulse-width channel. It holds a free-running counter that moves one step on each channel clock enable pulse. It also holds a period value and a duty value, and it drives a pulse output that is high while the counter is below the duty value.

Each of the two settings is kept in two stages. The first is a staged copy, which software writes and reads back. The second is an active copy, which the counter and the comparator use. While the channel runs, a new setting waits in the staged copy and moves to the active copy only at a safe point:
- the wrap at the end of a waveform period,
- a write to the counter,
- the channel being switched off.

Because of this, the output always shows one whole old waveform followed by whole new waveforms, never a mix of the two. While the channel is off, the active copy follows the staged copy on every cycle.

Two count patterns are available. Edge-aligned counting goes up and wraps. Centre-aligned counting goes up and then back down, which doubles the period. No data stream passes through this block. The write port is a plain single-cycle strobe that is always accepted, so there is no valid/ready handshake and there is no back-pressure.

Top module: `dbpwm_chan`

## Requirements
- R1: After reset:
  - the period read-back is 0xFF;
  - the duty read-back is 0x00;
  - the counter read-back is 0;
  - the output is at the idle level, which is 0 by default.
- R2: The write select `wr_sel` is decoded as follows: 0 is period, 1 is duty, 2 is counter and 3 is none. When the channel is on, a period or duty write changes only the staged copy. The read-back shows the written value from the next cycle on, and the waveform keeps its old settings until a transfer event.
- R3: When the channel is on, the staged period and duty move to the active copies on the tick where the counter completes a period. A write made in that same cycle is taken as well.
- R4: A counter write, with any data value, sets the counter to 0 on the next cycle. It restarts an upward count and transfers the staged settings to the active copies.
- R5: While `ch_en` is 0:
  - the counter is held at 0;
  - the output is at the idle level;
  - a period or duty write reaches the active copy at the same edge as the staged copy.
- R6: With `center`=0 and active period P>0, each tick advances the counter by one from 0 up to P-1, and the next tick returns it to 0. One output period is therefore P ticks.
- R7: With `center`=1 and active period P>0, the counter steps 0,1,…,P,P-1,…,1 and then returns to 0. One output period is therefore 2·P ticks, and the counter never exceeds P.
- R8: While the channel is on, the output is 1 when the counter is below the active duty and 0 otherwise. The duty value is buffered under the same rules as the period value.
- R9: An active period of 0 holds the counter at 0, so the output stays constant. Every tick counts as a period end, so that staged values can still be transferred.
- R10: With the channel on, the counter changes only on a cycle where `tick` is 1 or a counter write occurs.
- R11: A write with select code 3 changes neither the read-back values nor the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_en | input | 1 | Channel on |
| tick | input | 1 | Prescaled channel clock enable, one cycle wide |
| center | input | 1 | 1 = centre-aligned up/down count, 0 = edge-aligned up count |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 period, 1 duty, 2 counter, 3 none |
| wr_data | input | 8 | Write data (ignored for a counter write) |
| pwm_o | output | 1 | Pulse output |
| per_rd | output | 8 | Staged period read-back |
| duty_rd | output | 8 | Staged duty read-back |
| cnt_rd | output | 8 | Counter read-back |

## Verification
The counter, the staged copies and the active copies are all registers, so every result of a stimulus is due one clock edge after the cycle that presented it. This covers read-backs, the counter value and transfers. The output is a direct comparison of those registers, so it changes at that same edge.

The bench drives each stimulus just after a falling edge. At that moment it pushes the values it expects right after the next rising edge, and a monitor pops and compares them 1 ns after that rising edge. Each compare therefore lands in exactly the cycle where the result is first valid.

// File: rtl/dbpwm_pkg.sv
package dbpwm_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    SEL_PER  = 2'd0,
    SEL_DUTY = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;

  localparam int unsigned NUM_SETTINGS = 2;
  localparam int unsigned IDX_PER  = 0;
  localparam int unsigned IDX_DUTY = 1;
endpackage

// File: rtl/dbpwm_shadow.sv
module dbpwm_shadow #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         xfer,
  output logic [W-1:0] stage_q,
  output logic [W-1:0] act_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= RST_VAL;
      act_q   <= RST_VAL;
    end else begin
      if (wr) stage_q <= wdata;
      // a write in the transfer cycle is carried into the active copy
      if (xfer) act_q <= wr ? wdata : stage_q;
    end
  end

  assert_stage_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !xfer) |=> (act_q == $past(act_q)));
endmodule

// File: rtl/dbpwm_counter.sv
module dbpwm_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic         center,
  input  logic         clr,
  input  logic [W-1:0] per,
  output logic [W-1:0] cnt_q,
  output logic         prd_end
);
  logic         down_q;
  logic [W-1:0] cnt_d;
  logic         down_d;
  logic [W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    cnt_d   = cnt_q;
    down_d  = down_q;
    prd_end = 1'b0;
    if (!en || clr) begin
      cnt_d  = '0;
      down_d = 1'b0;
    end else if (tick) begin
      if (per == '0) begin
        cnt_d   = '0;
        down_d  = 1'b0;
        prd_end = 1'b1;
      end else if (!center) begin
        down_d = 1'b0;
        if (cnt_q >= per - 1'b1) begin
          cnt_d   = '0;
          prd_end = 1'b1;
        end else begin
          cnt_d = cnt_inc[W-1:0];
        end
      end else if (!down_q) begin
        if (cnt_inc >= {1'b0, per}) begin
          cnt_d  = per;
          down_d = 1'b1;
        end else begin
          cnt_d = cnt_inc[W-1:0];
        end
      end else begin
        if (cnt_q <= {{(W-1){1'b0}}, 1'b1}) begin
          cnt_d   = '0;
          down_d  = 1'b0;
          prd_end = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick && !clr) |=> $stable(cnt_q));
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  assert_off_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));
endmodule

// File: rtl/dbpwm_outcmp.sv
module dbpwm_outcmp #(
  parameter int unsigned W = 8,
  parameter logic IDLE_LVL = 1'b0
) (
  input  logic         en,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] duty,
  output logic         pwm
);
  always_comb begin
    if (!en) pwm = IDLE_LVL;
    else     pwm = (cnt < duty);
  end
endmodule

// File: rtl/dbpwm_chan.sv
module dbpwm_chan
  import dbpwm_pkg::*;
#(
  parameter int unsigned W = DATA_W,
  parameter logic [W-1:0] PER_RST  = {W{1'b1}},
  parameter logic [W-1:0] DUTY_RST = '0,
  parameter logic IDLE_LVL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ch_en,
  input  logic         tick,
  input  logic         center,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic         pwm_o,
  output logic [W-1:0] per_rd,
  output logic [W-1:0] duty_rd,
  output logic [W-1:0] cnt_rd
);
  logic [W-1:0] stage_v [NUM_SETTINGS];
  logic [W-1:0] act_v   [NUM_SETTINGS];
  logic         set_wr  [NUM_SETTINGS];
  logic         cnt_clr;
  logic         prd_end;
  logic         xfer;
  logic [W-1:0] cnt;

  assign set_wr[IDX_PER]  = wr_en && (wsel_e'(wr_sel) == SEL_PER);
  assign set_wr[IDX_DUTY] = wr_en && (wsel_e'(wr_sel) == SEL_DUTY);
  assign cnt_clr          = wr_en && (wsel_e'(wr_sel) == SEL_CNT);
  assign xfer             = !ch_en || prd_end || cnt_clr;

  for (genvar g = 0; g < NUM_SETTINGS; g++) begin : g_set
    localparam logic [W-1:0] RV = (g == IDX_PER) ? PER_RST : DUTY_RST;
    dbpwm_shadow #(.W(W), .RST_VAL(RV)) u_sh (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (set_wr[g]),
      .wdata   (wr_data),
      .xfer    (xfer),
      .stage_q (stage_v[g]),
      .act_q   (act_v[g])
    );
  end

  dbpwm_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ch_en),
    .tick    (tick),
    .center  (center),
    .clr     (cnt_clr),
    .per     (act_v[IDX_PER]),
    .cnt_q   (cnt),
    .prd_end (prd_end)
  );

  dbpwm_outcmp #(.W(W), .IDLE_LVL(IDLE_LVL)) u_cmp (
    .en   (ch_en),
    .cnt  (cnt),
    .duty (act_v[IDX_DUTY]),
    .pwm  (pwm_o)
  );

  assign per_rd  = stage_v[IDX_PER];
  assign duty_rd = stage_v[IDX_DUTY];
  assign cnt_rd  = cnt;

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && center) |-> (cnt <= act_v[IDX_PER]));
  assert_flat_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && $past(ch_en) && act_v[IDX_PER] == '0 && $past(act_v[IDX_PER]) == '0
     && $stable(act_v[IDX_DUTY])) |-> $stable(pwm_o));
endmodule

// File: tb/sim_dbpwm_chan.sv
`timescale 1ns/1ps
module sim_dbpwm_chan;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ch_en = 1'b0, tick = 1'b0, center = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [7:0] wr_data = 8'h00;
  logic       pwm_o;
  logic [7:0] per_rd, duty_rd, cnt_rd;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model state
  int m_sp = 255, m_ap = 255, m_sd = 0, m_ad = 0, m_cnt = 0;
  bit m_dn = 0;

  int    q_cnt [$];
  int    q_pwm [$];
  int    q_per [$];
  int    q_duty[$];
  string q_tag [$];

  always #2.5 clk = ~clk;

  dbpwm_chan u0 (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .tick(tick), .center(center),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pwm_o(pwm_o), .per_rd(per_rd), .duty_rd(duty_rd), .cnt_rd(cnt_rd)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // driver: one cycle of stimulus, expected results pushed for the following edge
  task automatic cyc(input bit en, input bit tk, input bit ctr, input bit we,
                     input int sel, input int d, input string tag);
    bit clr, pe;
    int ncnt;
    bit ndn;
    @(negedge clk);
    ch_en = en; tick = tk; center = ctr; wr_en = we;
    wr_sel = sel[1:0]; wr_data = d[7:0];
    clr = we && sel == 2;
    pe = 0; ncnt = m_cnt; ndn = m_dn;
    if (!en || clr) begin
      ncnt = 0; ndn = 0;
    end else if (tk) begin
      if (m_ap == 0) begin ncnt = 0; ndn = 0; pe = 1; end
      else if (!ctr) begin
        ndn = 0;
        if (m_cnt + 1 >= m_ap) begin ncnt = 0; pe = 1; end else ncnt = m_cnt + 1;
      end else if (!m_dn) begin
        if (m_cnt + 1 >= m_ap) begin ncnt = m_ap; ndn = 1; end else ncnt = m_cnt + 1;
      end else begin
        if (m_cnt <= 1) begin ncnt = 0; ndn = 0; pe = 1; end else ncnt = m_cnt - 1;
      end
    end
    if (we && sel == 0) m_sp = d;
    if (we && sel == 1) m_sd = d;
    if (!en || pe || clr) begin m_ap = m_sp; m_ad = m_sd; end
    m_cnt = ncnt; m_dn = ndn;
    q_cnt.push_back(m_cnt);
    q_pwm.push_back(en ? ((m_cnt < m_ad) ? 1 : 0) : 0);
    q_per.push_back(m_sp);
    q_duty.push_back(m_sd);
    q_tag.push_back(tag);
  endtask

  task automatic run(input bit en, input bit ctr, input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(en, 1'b1, ctr, 1'b0, 3, 0, tag);
  endtask

  // monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_tag.size() > 0) begin
        string t;
        t = q_tag.pop_front();
        chk(t, "cnt",  int'(cnt_rd),  q_cnt.pop_front());
        chk(t, "pwm",  int'(pwm_o),   q_pwm.pop_front());
        chk(t, "per",  int'(per_rd),  q_per.pop_front());
        chk(t, "duty", int'(duty_rd), q_duty.pop_front());
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "per reset", int'(per_rd), 255);
    chk("R1", "duty reset", int'(duty_rd), 0);
    chk("R1", "cnt reset", int'(cnt_rd), 0);
    chk("R1", "pwm reset", int'(pwm_o), 0);

    // R5: writes while off go straight to the active copy; counter and output idle
    cyc(0, 1, 0, 1, 0, 4, "R5");
    cyc(0, 1, 0, 1, 1, 2, "R5");
    run(0, 0, 4, "R5");
    // R6 edge-aligned, period 4 duty 2
    run(1, 0, 12, "R6");
    // R10: ticks only every other cycle
    for (int i = 0; i < 10; i++) cyc(1, i[0], 0, 1'b0, 3, 0, "R10");
    // R2: staged write mid-period, read-back immediate, waveform kept
    cyc(1, 1, 0, 1, 0, 6, "R2");
    cyc(1, 1, 0, 1, 1, 3, "R2");
    run(1, 0, 2, "R2");
    // R3: transfer at the period end, then the new waveform
    run(1, 0, 14, "R3");
    // R8: duty change, various levels
    cyc(1, 1, 0, 1, 1, 5, "R8");
    run(1, 0, 14, "R8");
    cyc(1, 1, 0, 1, 1, 0, "R8");
    run(1, 0, 10, "R8");
    cyc(1, 1, 0, 1, 1, 2, "R8");
    // R4: pending period then counter write with nonzero data
    run(1, 0, 3, "R4");
    cyc(1, 1, 0, 1, 0, 3, "R4");
    cyc(1, 0, 0, 1, 2, 8'h5A, "R4");
    run(1, 0, 9, "R4");
    // R7: centre-aligned
    run(1, 1, 20, "R7");
    cyc(1, 1, 1, 1, 0, 1, "R7");
    run(1, 1, 10, "R7");
    // R11: select code 3 changes nothing
    cyc(1, 1, 1, 1, 3, 8'hC3, "R11");
    run(1, 1, 4, "R11");
    // R9: zero period keeps output flat
    cyc(1, 1, 0, 1, 0, 0, "R9");
    cyc(1, 1, 0, 1, 1, 1, "R9");
    run(1, 0, 12, "R9");
    // R5: staged while on, then switch off transfers; enable again
    cyc(1, 1, 0, 1, 0, 5, "R5");
    cyc(1, 1, 0, 1, 1, 4, "R5");
    run(0, 0, 3, "R5");
    run(1, 0, 12, "R5");
    // R3: write in the same cycle as the wrap is taken too
    run(1, 0, 4, "R3");
    cyc(1, 1, 0, 1, 0, 2, "R3");
    run(1, 0, 8, "R3");

    while (q_tag.size() > 0) @(posedge clk);
    #10;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule